// File: doc/BRIEF.md
# Neighbour-Vote Sector Enable Controller

This controller decides, one coding unit at a time, whether the gateable intermediate sector of a motion-search scratchpad should be powered while that unit is searched. It holds a one-bit history map with one entry per 64x64 coding unit of the frame. Before a unit is encoded, the encoder pulses a start strobe with the unit's row and column. The controller then reads the unit's own entry and its eight surrounding entries and returns a registered enable with a one-cycle valid strobe.

After the unit is encoded, the encoder writes back one bit that says whether the unit actually needed the intermediate sector. Each write overwrites the map in place. As a result, when a later unit is decided, the neighbours above and to the left already hold current-frame results, while those below and to the right still hold results from the previous frame. The whole first frame after reset is searched with the sector enabled. Map dimensions and the vote threshold are parameters. The defaults are 17 rows by 30 columns, which covers a 1080p frame, and a threshold of 5.

Top module: `sector_vote_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it, `sect_en_valid` and `sect_en` are 0.
- R2: Reset sets every map entry to 1. An entry that has not been written since reset votes 1 in later frames.
- R3: A decision requested in cycle t is presented with `sect_en_valid` high in cycle t+2 for exactly one cycle. `sect_en` is 0 whenever `sect_en_valid` is 0.
- R4: The first frame runs from reset up to the second `frame_start` pulse. Every decision in it returns 1 whatever the map holds. Later `frame_start` pulses do not bring this state back.
- R5: Outside the first frame, the enable is 1 when the entry of the requested unit is 1.
- R6: Outside the first frame, the enable is 1 when at least VOTE_MIN (default 5) of the eight neighbouring entries are 1. With VOTE_MIN-1 neighbours at 1 and the unit's own entry at 0, the enable is 0.
- R7: A neighbour position outside the frame votes 0 but still counts as one of the eight. Columns do not wrap into the adjacent row: the right neighbour of column COLS-1 is outside the frame.
- R8: A write-back (`done_valid`=1) sets only the entry at (`done_row`,`done_col`) to `done_req`. No other entry changes.
- R9: A write-back presented in the same cycle as a start strobe, or in the following cycle, is seen by that decision (write before read).
- R10: Outside the first frame, the enable is 0 when the unit's own entry is 0 and fewer than VOTE_MIN neighbours are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; sets the map to all ones |
| frame_start | input | 1 | One-cycle pulse at each frame boundary |
| unit_start | input | 1 | Request a decision for (`unit_row`,`unit_col`) |
| unit_row | input | RW | Row of the unit to decide |
| unit_col | input | CW | Column of the unit to decide |
| done_valid | input | 1 | Write-back strobe after a unit is encoded |
| done_row | input | RW | Row of the encoded unit |
| done_col | input | CW | Column of the encoded unit |
| done_req | input | 1 | 1 if the encoded unit requested the intermediate sector |
| sect_en | output | 1 | Sector enable decision |
| sect_en_valid | output | 1 | One-cycle strobe marking `sect_en` as valid |

## Verification
The vote is tested at three kinds of position:
- At an interior unit, the bench raises the neighbour count one step at a time across the threshold (4 then 5). This separates a correct threshold from an off-by-one threshold.
- At corners and the top edge, out-of-frame positions must still count toward the eight without adding votes. Three in-frame ones at a corner must give 0, and five at an edge must give 1.
- At the last column, ones are placed at column 0 of the adjacent rows. A flat-index gather would wrap onto them and produce a false majority, so a correct design must return 0 there.

Separate cases cover the first frame being forced on over an all-zero map, and a write-back landing in the same cycle as a request or in the cycle after it.

// File: rtl/sector_vote_pkg.sv
package sector_vote_pkg;

  localparam int NBR_CNT  = 8;
  localparam int TAP_CNT  = 9;
  localparam int TAP_SELF = 4;

  function automatic int unsigned vote_count(input logic [NBR_CNT-1:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < NBR_CNT; i++) n += int'(v[i]);
    return n;
  endfunction

endpackage

// File: rtl/svc_frame_track.sv
module svc_frame_track (
  input  logic clk,
  input  logic rst,
  input  logic frame_start,
  output logic first_now
);
  logic seen_q;
  logic first_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q  <= 1'b0;
      first_q <= 1'b1;
    end else if (frame_start) begin
      seen_q <= 1'b1;
      if (seen_q) first_q <= 1'b0;
    end
  end

  // a second boundary in this very cycle already ends the first frame
  assign first_now = first_q & ~(frame_start & seen_q);
endmodule

// File: rtl/svc_map.sv
module svc_map #(
  parameter int ROWS = 17,
  parameter int COLS = 30,
  parameter int RW   = $clog2(ROWS),
  parameter int CW   = $clog2(COLS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [RW-1:0]        wr_row,
  input  logic [CW-1:0]        wr_col,
  input  logic                 wr_bit,
  input  logic [RW-1:0]        rd_row,
  input  logic [CW-1:0]        rd_col,
  output logic                 self_bit,
  output logic [7:0]           nbr_bits,
  output logic [ROWS*COLS-1:0] map_bits
);
  import sector_vote_pkg::*;

  localparam int DEPTH = ROWS * COLS;
  localparam int AW    = $clog2(DEPTH);

  logic [DEPTH-1:0]   map_q;
  logic [TAP_CNT-1:0] taps;
  logic               wr_ok;
  logic [AW-1:0]      wr_idx;

  always_comb begin
    wr_ok  = (int'(wr_row) < ROWS) && (int'(wr_col) < COLS);
    wr_idx = AW'(int'(wr_row) * COLS + int'(wr_col));
  end

  always_ff @(posedge clk) begin
    if (rst) map_q <= '1;
    else if (wr_en && wr_ok) map_q[wr_idx] <= wr_bit;
  end

  for (genvar g = 0; g < TAP_CNT; g++) begin : g_tap
    localparam int DR = g / 3 - 1;
    localparam int DC = g % 3 - 1;
    logic tap;
    always_comb begin
      int r;
      int c;
      r   = int'(rd_row) + DR;
      c   = int'(rd_col) + DC;
      tap = 1'b0;
      if (r >= 0 && r < ROWS && c >= 0 && c < COLS) begin
        if (wr_en && int'(wr_row) == r && int'(wr_col) == c) tap = wr_bit;
        else tap = map_q[AW'(r * COLS + c)];
      end
    end
    assign taps[g] = tap;
  end

  assign self_bit = taps[TAP_SELF];
  assign nbr_bits = {taps[8:5], taps[3:0]};
  assign map_bits = map_q;
endmodule

// File: rtl/svc_tally.sv
module svc_tally #(
  parameter int VOTE_MIN = 5
) (
  input  logic       forced,
  input  logic       self_bit,
  input  logic [7:0] nbr_bits,
  output logic       enable
);
  import sector_vote_pkg::*;

  logic majority;
  always_comb begin
    majority = vote_count(nbr_bits) >= VOTE_MIN;
    enable   = forced | self_bit | majority;
  end
endmodule

// File: rtl/sector_vote_ctrl.sv
module sector_vote_ctrl #(
  parameter int ROWS     = 17,
  parameter int COLS     = 30,
  parameter int VOTE_MIN = 5,
  parameter int RW       = $clog2(ROWS),
  parameter int CW       = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_start,
  input  logic          unit_start,
  input  logic [RW-1:0] unit_row,
  input  logic [CW-1:0] unit_col,
  input  logic          done_valid,
  input  logic [RW-1:0] done_row,
  input  logic [CW-1:0] done_col,
  input  logic          done_req,
  output logic          sect_en,
  output logic          sect_en_valid
);
  logic                 first_now;
  logic                 a_vld;
  logic                 a_forced;
  logic [RW-1:0]        a_row;
  logic [CW-1:0]        a_col;
  logic                 self_bit;
  logic [7:0]           nbr_bits;
  logic [ROWS*COLS-1:0] map_bits;
  logic                 decision;

  svc_frame_track u_frame (
    .clk        (clk),
    .rst        (rst),
    .frame_start(frame_start),
    .first_now  (first_now)
  );

  // stage A: capture the request and the first-frame state
  always_ff @(posedge clk) begin
    if (rst) begin
      a_vld    <= 1'b0;
      a_forced <= 1'b0;
      a_row    <= '0;
      a_col    <= '0;
    end else begin
      a_vld <= unit_start;
      if (unit_start) begin
        a_forced <= first_now;
        a_row    <= unit_row;
        a_col    <= unit_col;
      end
    end
  end

  svc_map #(.ROWS(ROWS), .COLS(COLS), .RW(RW), .CW(CW)) u_map (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (done_valid),
    .wr_row  (done_row),
    .wr_col  (done_col),
    .wr_bit  (done_req),
    .rd_row  (a_row),
    .rd_col  (a_col),
    .self_bit(self_bit),
    .nbr_bits(nbr_bits),
    .map_bits(map_bits)
  );

  svc_tally #(.VOTE_MIN(VOTE_MIN)) u_tally (
    .forced  (a_forced),
    .self_bit(self_bit),
    .nbr_bits(nbr_bits),
    .enable  (decision)
  );

  // stage B: registered result
  always_ff @(posedge clk) begin
    if (rst) begin
      sect_en_valid <= 1'b0;
      sect_en       <= 1'b0;
    end else begin
      sect_en_valid <= a_vld;
      sect_en       <= a_vld & decision;
    end
  end
endmodule

// File: rtl/sector_vote_chk.sv
module sector_vote_chk #(
  parameter int ROWS = 17,
  parameter int COLS = 30,
  parameter int RW   = $clog2(ROWS),
  parameter int CW   = $clog2(COLS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 frame_start,
  input logic                 unit_start,
  input logic                 done_valid,
  input logic [RW-1:0]        done_row,
  input logic [CW-1:0]        done_col,
  input logic                 done_req,
  input logic                 sect_en,
  input logic                 sect_en_valid,
  input logic [ROWS*COLS-1:0] map_bits
);
  localparam int AW = $clog2(ROWS * COLS);

  logic          c_seen, c_first, c_p1, c_p2;
  logic          wr_pend;
  logic [AW-1:0] wr_idx;
  logic          wr_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      c_seen  <= 1'b0;
      c_first <= 1'b1;
      c_p1    <= 1'b0;
      c_p2    <= 1'b0;
      wr_pend <= 1'b0;
      wr_idx  <= '0;
      wr_val  <= 1'b0;
    end else begin
      if (frame_start) begin
        c_seen <= 1'b1;
        if (c_seen) c_first <= 1'b0;
      end
      c_p1    <= unit_start & c_first & ~(frame_start & c_seen);
      c_p2    <= c_p1;
      wr_pend <= done_valid && (int'(done_row) < ROWS) && (int'(done_col) < COLS);
      wr_idx  <= AW'(int'(done_row) * COLS + int'(done_col));
      wr_val  <= done_req;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!sect_en_valid && !sect_en));

  // R2
  map_all_ones_chk: assert property (@(posedge clk) $past(rst) |-> (&map_bits));

  // R3
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    sect_en_valid |-> $past(unit_start, 2));

  // R3
  en_gated_chk: assert property (@(posedge clk) disable iff (rst)
    !sect_en_valid |-> !sect_en);

  // R4
  first_frame_on_chk: assert property (@(posedge clk) disable iff (rst)
    c_p2 |-> (sect_en_valid && sect_en));

  // R8
  writeback_lands_chk: assert property (@(posedge clk) disable iff (rst)
    wr_pend |-> (map_bits[wr_idx] == wr_val));
endmodule

bind sector_vote_ctrl sector_vote_chk #(.ROWS(ROWS), .COLS(COLS), .RW(RW), .CW(CW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .frame_start  (frame_start),
  .unit_start   (unit_start),
  .done_valid   (done_valid),
  .done_row     (done_row),
  .done_col     (done_col),
  .done_req     (done_req),
  .sect_en      (sect_en),
  .sect_en_valid(sect_en_valid),
  .map_bits     (map_bits)
);

// File: tb/sim_sector_vote_ctrl.sv
module sim_sector_vote_ctrl;
  localparam int ROWS = 17;
  localparam int COLS = 30;
  localparam int RW   = $clog2(ROWS);
  localparam int CW   = $clog2(COLS);

  typedef struct packed {
    logic       dec;   // 1: decision with expected value, 0: write-back
    logic [4:0] row;
    logic [4:0] col;
    logic       val;   // expected enable, or write-back bit
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t VT [NV] = '{
    '{1'b1, 5'd8,  5'd10, 1'b0, 4'd10}, // R10 all zero
    '{1'b0, 5'd8,  5'd10, 1'b1, 4'd8},
    '{1'b1, 5'd8,  5'd10, 1'b1, 4'd5},  // R5 own entry set
    '{1'b1, 5'd8,  5'd11, 1'b0, 4'd8},  // R8 neighbour still 0 (one vote)
    '{1'b0, 5'd8,  5'd10, 1'b0, 4'd8},
    '{1'b1, 5'd8,  5'd10, 1'b0, 4'd8},  // R8 cleared again
    '{1'b0, 5'd2,  5'd3,  1'b1, 4'd6},
    '{1'b0, 5'd2,  5'd4,  1'b1, 4'd6},
    '{1'b0, 5'd2,  5'd5,  1'b1, 4'd6},
    '{1'b0, 5'd3,  5'd3,  1'b1, 4'd6},
    '{1'b1, 5'd3,  5'd4,  1'b0, 4'd6},  // R6 four votes
    '{1'b0, 5'd3,  5'd5,  1'b1, 4'd6},
    '{1'b1, 5'd3,  5'd4,  1'b1, 4'd6},  // R6 five votes
    '{1'b0, 5'd0,  5'd1,  1'b1, 4'd7},
    '{1'b0, 5'd1,  5'd0,  1'b1, 4'd7},
    '{1'b0, 5'd1,  5'd1,  1'b1, 4'd7},
    '{1'b1, 5'd0,  5'd0,  1'b0, 4'd7},  // R7 corner, 3 in frame
    '{1'b0, 5'd15, 5'd28, 1'b1, 4'd7},
    '{1'b0, 5'd15, 5'd29, 1'b1, 4'd7},
    '{1'b0, 5'd16, 5'd28, 1'b1, 4'd7},
    '{1'b1, 5'd16, 5'd29, 1'b0, 4'd7},  // R7 far corner
    '{1'b0, 5'd0,  5'd14, 1'b1, 4'd7},
    '{1'b0, 5'd0,  5'd16, 1'b1, 4'd7},
    '{1'b0, 5'd1,  5'd14, 1'b1, 4'd7},
    '{1'b0, 5'd1,  5'd15, 1'b1, 4'd7},
    '{1'b0, 5'd1,  5'd16, 1'b1, 4'd7},
    '{1'b1, 5'd0,  5'd15, 1'b1, 4'd7},  // R7 top edge, 5 of 5
    '{1'b0, 5'd3,  5'd0,  1'b1, 4'd7},
    '{1'b0, 5'd4,  5'd0,  1'b1, 4'd7},
    '{1'b0, 5'd5,  5'd0,  1'b1, 4'd7},
    '{1'b0, 5'd2,  5'd28, 1'b1, 4'd7},
    '{1'b0, 5'd2,  5'd29, 1'b1, 4'd7},
    '{1'b1, 5'd3,  5'd29, 1'b0, 4'd7},  // R7 no wrap at last column
    '{1'b1, 5'd3,  5'd5,  1'b1, 4'd5},  // R5
    '{1'b1, 5'd9,  5'd20, 1'b0, 4'd10}  // R10
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          frame_start = 1'b0;
  logic          unit_start = 1'b0;
  logic [RW-1:0] unit_row = '0;
  logic [CW-1:0] unit_col = '0;
  logic          done_valid = 1'b0;
  logic [RW-1:0] done_row = '0;
  logic [CW-1:0] done_col = '0;
  logic          done_req = 1'b0;
  logic          sect_en;
  logic          sect_en_valid;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  sector_vote_ctrl #(.ROWS(ROWS), .COLS(COLS)) u0 (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .unit_start(unit_start), .unit_row(unit_row), .unit_col(unit_col),
    .done_valid(done_valid), .done_row(done_row), .done_col(done_col),
    .done_req(done_req), .sect_en(sect_en), .sect_en_valid(sect_en_valid)
  );

  task automatic check(input bit ok, input int rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d actual=%0d expected=%0d (t=%0t)", rq, act, exp, $time);
    end
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic wb(input int r, input int c, input bit v);
    @(negedge clk);
    done_valid = 1'b1; done_row = RW'(r); done_col = CW'(c); done_req = v;
    @(negedge clk); done_valid = 1'b0;
  endtask

  // R3: valid low one cycle after the request, high two cycles after
  task automatic decide(input int r, input int c, input bit exp, input int rq);
    @(negedge clk);
    unit_start = 1'b1; unit_row = RW'(r); unit_col = CW'(c);
    @(negedge clk); unit_start = 1'b0;
    check(sect_en_valid == 1'b0, 3, int'(sect_en_valid), 0);
    @(negedge clk);
    check(sect_en_valid == 1'b1, 3, int'(sect_en_valid), 1);
    check(sect_en == exp, rq, int'(sect_en), int'(exp));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 outputs quiet during reset
    check(sect_en_valid == 1'b0 && sect_en == 1'b0, 1, int'(sect_en_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check(sect_en_valid == 1'b0 && sect_en == 1'b0, 1, int'(sect_en_valid), 0);

    // first frame: every unit decided then reported as not needing the sector
    pulse_frame();
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        decide(r, c, 1'b1, 4);
        wb(r, c, 1'b0);
      end
    decide(8, 8, 1'b1, 4); // R4 forced over an all-zero map

    // second frame: table of vectors
    pulse_frame();
    for (int i = 0; i < NV; i++) begin
      if (VT[i].dec) decide(int'(VT[i].row), int'(VT[i].col), VT[i].val, int'(VT[i].rq));
      else wb(int'(VT[i].row), int'(VT[i].col), VT[i].val);
    end

    // R3 strobe lasts exactly one cycle
    @(negedge clk);
    check(sect_en_valid == 1'b0, 3, int'(sect_en_valid), 0);

    // R9 write-back in the same cycle as the request
    @(negedge clk);
    unit_start = 1'b1; unit_row = RW'(12); unit_col = CW'(12);
    done_valid = 1'b1; done_row = RW'(12); done_col = CW'(12); done_req = 1'b1;
    @(negedge clk); unit_start = 1'b0; done_valid = 1'b0;
    @(negedge clk);
    check(sect_en_valid && sect_en == 1'b1, 9, int'(sect_en), 1);

    // R9 write-back in the cycle after the request
    @(negedge clk);
    unit_start = 1'b1; unit_row = RW'(12); unit_col = CW'(12);
    @(negedge clk); unit_start = 1'b0;
    done_valid = 1'b1; done_row = RW'(12); done_col = CW'(12); done_req = 1'b0;
    @(negedge clk); done_valid = 1'b0;
    check(sect_en_valid && sect_en == 1'b0, 9, int'(sect_en), 0);

    // R4 a third boundary does not restore the forced state
    pulse_frame();
    decide(8, 10, 1'b0, 4);

    // R1 / R2 reset mid-stream restores ones
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check(sect_en_valid == 1'b0 && sect_en == 1'b0, 1, int'(sect_en), 0);
    rst = 1'b0;
    pulse_frame();
    pulse_frame();
    decide(8, 10, 1'b1, 2);
    decide(12, 12, 1'b1, 2);

    finish_run();
  end
endmodule